// File: doc/BRIEF.md
# Dual-Source Clock Output Divider

This block produces one divided clock output from a choice of two parent clocks. One parent is a slow 32768 Hz timekeeping clock. The other is a fast clock of roughly 4 MHz. Both parents are asynchronous to the block's system clock. Each parent passes through its own two-stage synchronizer. Every rising and every falling parent edge becomes a one-cycle event in the system clock domain. The output toggles after a programmed number of these events, so it keeps a 50% duty cycle at every ratio, including a ratio of 1.

Software programs the block through a single 8-bit control byte:

| Bits | Field |
|------|-------|
| bit 0 | output enable |
| bits 3:1 | power-of-two post-divider code |
| bit 4 | parent select |
| bits 7:5 | pre-divider code |

The pre-divider ratios run 1, 2, 4, 8, 16, 32 and 64 for codes 0 to 6, and code 7 gives 122. The pre-divider acts only on the fast parent. A written byte is held as a pending setting. It becomes active only at a period boundary, which is the instant the output would next rise after a complete low phase. A disabled block takes it at once. In both cases the counters restart, so enabling, disabling, retuning and changing parent never produce a shortened pulse.

Top module: `dual_src_clkdiv`

## Requirements
- R1: A write stores the byte, and `cfg_rdata_o` shows it from the next cycle on. The fields are: bit 0 enable, bits 3:1 post code Q, bit 4 parent select (0 = slow parent, 1 = fast parent), bits 7:5 pre code P.
- R2: After reset the stored byte is 0x00 and `clk_o` is low.
- R3: With the slow parent selected, each high phase and each low phase of `clk_o` lasts 2^Q slow-parent half periods.
- R4: With the fast parent selected, each phase lasts R(P)·2^Q fast-parent half periods. R(P) is 1, 2, 4, 8, 16, 32, 64 for P = 0..6, and 122 for P = 7.
- R5: With the slow parent selected, the pre-divider code has no effect on the output timing.
- R6: While the active setting has enable = 0, `clk_o` stays low. `clk_o` only rises under an enabled setting.
- R7: A new setting written while the output runs does not cut the current high phase short. It becomes active only at the end of a low phase, with both counters restarted.
- R8: Changing the parent takes effect at a period boundary. After the change, the output follows the new parent at the newly programmed ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_par_i | input | 1 | 32768 Hz parent clock, asynchronous |
| fast_par_i | input | 1 | ~4 MHz parent clock, asynchronous |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Stored control byte |
| clk_o | output | 1 | Divided, gated output clock |

## Verification
The assertions assume that each parent toggles no faster than once every few system clock cycles. This lets the synchronizers turn every parent edge into a separate event. Under that assumption, any change of `clk_o` can be traced to an event in the previous cycle.

The stimulus meets this assumption. The slow parent toggles every 20 system cycles and the fast parent every 5. Both parents are offset from the system clock edge by a fixed amount, so event spacing is exact. Writes are applied on the falling edge of the system clock and last exactly one cycle.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    localparam int PRE_CODE_W     = 3;
    localparam int POST_CODE_W    = 3;
    localparam int NUM_PARENTS    = 2;
    localparam int LAST_PRE_RATIO = 122;
    localparam int PRE_LAST_CODE  = (1 << PRE_CODE_W) - 1;
    localparam int PRE_CNT_W      = $clog2(LAST_PRE_RATIO);
    localparam int POST_CNT_W     = (1 << POST_CODE_W) - 1;

    // Field order is the software-visible bit layout, msb first.
    typedef struct packed {
        logic [PRE_CODE_W-1:0]  pre;
        logic                   sel;
        logic [POST_CODE_W-1:0] post;
        logic                   en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PRE_CODE_W-1:0] code);
        int r;
        if (int'(code) == PRE_LAST_CODE) r = LAST_PRE_RATIO;
        else                             r = 1 << code;
        return PRE_CNT_W'(r - 1);
    endfunction

    function automatic logic [POST_CNT_W-1:0] post_limit(input logic [POST_CODE_W-1:0] code);
        return POST_CNT_W'((1 << code) - 1);
    endfunction
endpackage

// File: rtl/clkdiv_sync.sv
`timescale 1ns/1ps
module clkdiv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.chain = {q.chain[STAGES-2:0], async_i};
        d.last  = q.chain[STAGES-1];
        edge_o  = q.chain[STAGES-1] ^ q.last;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/clkdiv_cfg.sv
`timescale 1ns/1ps
module clkdiv_cfg
    import clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             boundary_i,
    output logic [CTL_W-1:0] rdata_o,
    output ctl_t             act_o,
    output logic             restart_o
);
    typedef struct packed {
        ctl_t pend;
        ctl_t act;
    } cfg_st_t;

    cfg_st_t q, d;
    logic    apply;

    always_comb begin
        d     = q;
        apply = (q.pend != q.act) && (!q.act.en || boundary_i);
        if (we_i)  d.pend = ctl_t'(wdata_i);
        if (apply) d.act  = q.pend;
        restart_o = apply;
        rdata_o   = q.pend;
        act_o     = q.act;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic restart_i,
    input  ctl_t act_i,
    output logic out_o,
    output logic boundary_o
);
    typedef struct packed {
        logic [PRE_CNT_W-1:0]  pre;
        logic [POST_CNT_W-1:0] post;
        logic                  out;
    } core_st_t;

    core_st_t              q, d;
    logic [PRE_CNT_W-1:0]  pre_lim;
    logic [POST_CNT_W-1:0] post_lim;
    logic                  pre_end, post_end;

    always_comb begin
        d          = q;
        pre_lim    = act_i.sel ? pre_limit(act_i.pre) : '0;
        post_lim   = post_limit(act_i.post);
        pre_end    = (q.pre == pre_lim);
        post_end   = (q.post == post_lim);
        boundary_o = act_i.en && evt_i && !q.out && pre_end && post_end;

        if (restart_i || !act_i.en) begin
            d = '0;
        end else if (evt_i) begin
            if (pre_end) begin
                d.pre = '0;
                if (post_end) begin
                    d.post = '0;
                    d.out  = ~q.out;
                end else begin
                    d.post = q.post + 1'b1;
                end
            end else begin
                d.pre = q.pre + 1'b1;
            end
        end
        out_o = q.out;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/dual_src_clkdiv.sv
`timescale 1ns/1ps
module dual_src_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       slow_par_i,
    input  logic       fast_par_i,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    output logic       clk_o
);
    logic [NUM_PARENTS-1:0] par_in;
    logic [NUM_PARENTS-1:0] par_edge;
    ctl_t                   act_cfg;
    logic                   evt, boundary, restart;

    assign par_in = {fast_par_i, slow_par_i};

    for (genvar g = 0; g < NUM_PARENTS; g++) begin : g_sync
        clkdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .async_i(par_in[g]),
            .edge_o (par_edge[g])
        );
    end

    assign evt = par_edge[act_cfg.sel];

    clkdiv_cfg u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (cfg_we_i),
        .wdata_i   (cfg_wdata_i),
        .boundary_i(boundary),
        .rdata_o   (cfg_rdata_o),
        .act_o     (act_cfg),
        .restart_o (restart)
    );

    clkdiv_core u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt),
        .restart_i (restart),
        .act_i     (act_cfg),
        .out_o     (clk_o),
        .boundary_o(boundary)
    );
endmodule

// File: rtl/dual_src_clkdiv_chk.sv
`timescale 1ns/1ps
module dual_src_clkdiv_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cfg_we_i,
    input logic [7:0] cfg_wdata_i,
    input logic [7:0] cfg_rdata_o,
    input logic       clk_o,
    input logic [7:0] act_cfg,
    input logic       evt
);
    assert_write_readback_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> (cfg_rdata_o == $past(cfg_wdata_i)));

    assert_rise_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_o) |-> act_cfg[0]);

    assert_disabled_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !act_cfg[0] |-> !clk_o);

    assert_apply_in_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_cfg != $past(act_cfg)) |-> (!$past(clk_o) && !clk_o));

    assert_toggle_on_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_o != $past(clk_o)) |-> $past(evt));
endmodule

bind dual_src_clkdiv dual_src_clkdiv_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .clk_o      (clk_o),
    .act_cfg    (act_cfg),
    .evt        (evt)
);

// File: tb/dual_src_clkdiv_test.sv
`timescale 1ns/1ps
module dual_src_clkdiv_test;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       slow_par_i = 1'b0;
    logic       fast_par_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic [7:0] cfg_rdata_o;
    logic       clk_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_chg = 0;
    logic mon_prev = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    // slow parent: 20 system cycles per half period, fast parent: 5
    localparam int HS = 20;
    localparam int HF = 5;

    dual_src_clkdiv uut (
        .clk_i(clk_i), .rst_ni(rst_ni), .slow_par_i(slow_par_i), .fast_par_i(fast_par_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .clk_o(clk_o)
    );

    always #2.5 clk_i = ~clk_i;
    initial begin #1; forever #100 slow_par_i = ~slow_par_i; end
    initial begin #1; forever #25  fast_par_i = ~fast_par_i; end

    function automatic logic [7:0] ctl(input int pre, input int sel, input int post, input int en);
        return {3'(pre), 1'(sel), 3'(post), 1'(en)};
    endfunction

    // monitor: measures every phase length and pops an expectation if one is queued
    always @(negedge clk_i) begin
        cyc = cyc + 1;
        if (rst_ni && clk_o !== mon_prev) begin
            int len;
            len = cyc - last_chg;
            last_chg = cyc;
            mon_prev = clk_o;
            if (exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (len != e) begin
                    errors++;
                    $display("FAIL %s: phase length actual %0d expected %0d", t, len, e);
                end
            end
        end
    end

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk_i);
        cfg_we_i = 1'b1;
        cfg_wdata_i = v;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
    endtask

    task automatic wait_rise();
        logic was;
        was = clk_o;
        forever begin
            @(negedge clk_i);
            if (clk_o && !was) break;
            was = clk_o;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk_i);
    endtask

    task automatic push(input int e, input int n, input string t);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
    endtask

    task automatic run_cfg(input logic [7:0] v, input int e, input int n, input string t);
        write_cfg(v);
        wait_rise();
        wait_rise();
        @(posedge clk_i);
        push(e, n, t);
        drain();
    endtask

    task automatic hold_low(input int n, input string t);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            if (clk_o) seen++;
        end
        checks++;
        if (seen != 0) begin
            errors++;
            $display("FAIL %s: high samples actual %0d expected 0", t, seen);
        end
    endtask

    task automatic check_rd(input logic [7:0] e, input string t);
        checks++;
        if (cfg_rdata_o !== e) begin
            errors++;
            $display("FAIL %s: rdata actual %h expected %h", t, cfg_rdata_o, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R2: reset state
        checks++;
        if (clk_o !== 1'b0) begin
            errors++;
            $display("FAIL R2: clk_o actual %b expected 0", clk_o);
        end
        check_rd(8'h00, "R2");
        // R6: disabled after reset keeps the output low
        hold_low(300, "R6");

        // R1: field layout and readback
        write_cfg(ctl(5, 1, 0, 1));
        check_rd(8'hB1, "R1");
        write_cfg(ctl(0, 0, 2, 1));
        check_rd(8'h05, "R1");

        // R3: slow parent, post-divider only
        run_cfg(ctl(0, 0, 0, 1), HS,     4, "R3");
        run_cfg(ctl(0, 0, 2, 1), 4 * HS, 4, "R3");
        // R5: pre code ignored on the slow parent
        run_cfg(ctl(7, 0, 1, 1), 2 * HS, 4, "R5");
        // R4 / R8: fast parent with pre and post ratios
        run_cfg(ctl(0, 1, 0, 1), HF,           4, "R8");
        run_cfg(ctl(7, 1, 0, 1), 122 * HF,     4, "R4");
        run_cfg(ctl(3, 1, 1, 1), 16 * HF,      4, "R4");
        run_cfg(ctl(7, 1, 1, 1), 244 * HF,     2, "R4");
        run_cfg(ctl(6, 1, 2, 1), 256 * HF,     2, "R4");

        // R7: disable during a high phase completes that phase, then stays low
        run_cfg(ctl(0, 1, 3, 1), 8 * HF, 2, "R4");
        wait_rise();
        @(posedge clk_i);
        push(8 * HF, 1, "R7");
        write_cfg(ctl(0, 1, 3, 0));
        drain();
        hold_low(600, "R6");

        // R7: retune during a high phase does not truncate it; R8 switch to slow
        run_cfg(ctl(0, 1, 3, 1), 8 * HF, 2, "R4");
        wait_rise();
        @(posedge clk_i);
        push(8 * HF, 1, "R7");
        write_cfg(ctl(0, 0, 0, 1));
        drain();
        wait_rise();
        @(posedge clk_i);
        push(HS, 4, "R8");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: cycles actual 150000 expected completion earlier");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule